// File: doc/BRIEF.md
# Synchronous burst SRAM access controller

This block is the registered front end of a single-cycle synchronous SRAM built from 32-bit words split into four byte lanes. On each rising clock edge it samples three chip selects, two address strobes, an advance input and the write controls. A selected strobe loads a start address and clears a two-bit burst counter. Each later edge with advance asserted moves to the next word of a four-word group, in either linear or interleaved order. The array is flow-through: the addressed word reaches the data outputs in the same cycle that its address was registered. This gives a 2-1-1-1 burst, with one clock for the address and then one word on every clock.

Writes use the address held by the access that is already open. The lanes written at an edge come from a global write input combined with a byte-write enable and four per-lane inputs. The output driver is gated with no clock by an output-enable input and by a sleep input. It is also turned off by any edge that writes, and it stays off until the next strobe or advance edge that does not write. Array depth is 2^ADDR_W words. The full-size part uses ADDR_W = 15, which is 32,768 words.

Top module: `sync_burst_sram`

## Requirements
- R1: With write_all_ni LOW during an open access, all four lanes of the current word are written from data_i, whatever byte_wr_en_ni and lane_wr_ni hold.
- R2: With write_all_ni HIGH and byte_wr_en_ni LOW, lane i (data bits 8i+7:8i) is written exactly when lane_wr_ni[i] is LOW; the other lanes keep their contents, and all four LOW gives a full-word write.
- R3: With write_all_ni HIGH and either byte_wr_en_ni HIGH or lane_wr_ni equal to 4'b1111, the edge is a read and no lane of the array changes.
- R4: An access opens only on a strobe edge with sel_a_ni LOW, sel_b_i HIGH and sel_c_ni LOW. A strobe edge under any other select pattern closes the open access, and data_oe_o stays LOW until the next access opens.
- R5: proc_strobe_ni is ignored while sel_a_ni is HIGH, so an open burst continues as if no strobe occurred. ctrl_strobe_ni is acted on under any select pattern. When both strobes are seen, proc_strobe_ni takes priority.
- R6: In the cycle after the edge that opens an access, data_oe_o is HIGH and data_o shows the word at the loaded address. Each following edge with advance_ni LOW shows the next burst word one cycle later.
- R7: Burst words share all address bits above bit 1. With burst_order_i LOW the low two bits follow (start + n) mod 4. With burst_order_i HIGH they follow start XOR n. The sequence wraps after four words.
- R8: An edge with advance_ni HIGH and no strobe leaves the burst address unchanged.
- R9: out_en_ni HIGH forces data_oe_o LOW at once, without a clock edge. data_o is zero whenever data_oe_o is LOW.
- R10: After an edge that writes, data_oe_o is LOW. It stays LOW through hold edges until a strobe edge, or an advance edge that does not write.
- R11: While sleep_i is HIGH, data_oe_o is LOW, no strobe opens an access, and any open access is closed. Array contents are kept.
- R12: After reset, data_oe_o is LOW and no access is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address sampled on strobe edges |
| sel_a_ni | input | 1 | Chip select, active low; also gates proc_strobe_ni |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_ni | input | 1 | Chip select, active low |
| proc_strobe_ni | input | 1 | Processor-side address strobe, active low |
| ctrl_strobe_ni | input | 1 | Controller-side address strobe, active low |
| advance_ni | input | 1 | Step burst counter, active low |
| write_all_ni | input | 1 | Global write of all lanes, active low |
| byte_wr_en_ni | input | 1 | Enables per-lane writes, active low |
| lane_wr_ni | input | LANES | Per-lane write select, active low |
| out_en_ni | input | 1 | Output enable, active low, unclocked |
| sleep_i | input | 1 | Sleep request, active high |
| burst_order_i | input | 1 | 0 linear, 1 interleaved burst order |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Read data |
| data_oe_o | output | 1 | Drive enable for the data pins |

## Verification
The assertions assume that the select, strobe, advance and write inputs are stable around each rising edge. They also assume sleep_i changes only while the block is deselected or when the bench expects the access to end. The stimulus drives every input one time unit after a rising edge and reads outputs just before the next one, so every sample falls between edges. Random bursts stay inside a 64-word window that is first filled by full-word write bursts, which keeps every read aimed at a word whose expected value is known.

// File: rtl/sync_sram_pkg.sv
package sync_sram_pkg;
  localparam int unsigned BURST_W = 2;

  // low address bits of burst word n
  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] n,
    input logic               interleave
  );
    return interleave ? (start ^ n) : (start + n);
  endfunction
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
  parameter int unsigned LANES = 4
) (
  input  logic             en_i,
  input  logic             write_all_ni,
  input  logic             byte_wr_en_ni,
  input  logic [LANES-1:0] lane_wr_ni,
  output logic [LANES-1:0] lane_we_o
);
  always_comb begin
    lane_we_o = '0;
    if (en_i) begin
      if (!write_all_ni)       lane_we_o = '1;
      else if (!byte_wr_en_ni) lane_we_o = ~lane_wr_ni;
    end
  end
endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
  import sync_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
    end else if (adv_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign addr_o = {base_q[ADDR_W-1:BURST_W],
                   burst_low(base_q[BURST_W-1:0], cnt_q, order_i)};
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    // flow-through read
    assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_a_ni,
  input  logic              sel_b_i,
  input  logic              sel_c_ni,
  input  logic              proc_strobe_ni,
  input  logic              ctrl_strobe_ni,
  input  logic              advance_ni,
  input  logic              write_all_ni,
  input  logic              byte_wr_en_ni,
  input  logic [LANES-1:0]  lane_wr_ni,
  input  logic              out_en_ni,
  input  logic              sleep_i,
  input  logic              burst_order_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int unsigned LANE_W = DATA_W / LANES;

  logic              selected, strobe, load, adv, wr;
  logic              active_q, drive_q;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] rdata;

  assign selected = !sel_a_ni && sel_b_i && !sel_c_ni;
  // processor strobe only counts while sel_a is asserted
  assign strobe   = (!proc_strobe_ni && !sel_a_ni) || !ctrl_strobe_ni;
  assign load     = !sleep_i && strobe && selected;
  assign adv      = !sleep_i && !strobe && active_q && !advance_ni;
  assign wr       = |lane_we;

  sram_wr_decode #(.LANES(LANES)) u_wr_decode (
    .en_i          (active_q && !sleep_i),
    .write_all_ni  (write_all_ni),
    .byte_wr_en_ni (byte_wr_en_ni),
    .lane_wr_ni    (lane_wr_ni),
    .lane_we_o     (lane_we)
  );

  sram_burst_addr #(.ADDR_W(ADDR_W)) u_burst_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .adv_i   (adv),
    .order_i (burst_order_i),
    .addr_i  (addr_i),
    .addr_o  (cur_addr)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (lane_we),
    .addr_i  (cur_addr),
    .wdata_i (data_i),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      drive_q  <= 1'b0;
    end else if (sleep_i) begin
      active_q <= 1'b0;
      drive_q  <= 1'b0;
    end else if (strobe) begin
      active_q <= selected;
      drive_q  <= selected;
    end else if (adv) begin
      drive_q  <= !wr;
    end else if (wr) begin
      drive_q  <= 1'b0;
    end
  end

  assign data_oe_o = drive_q && !out_en_ni && !sleep_i;
  assign data_o    = data_oe_o ? rdata : '0;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_a_ni,
  input logic              sel_b_i,
  input logic              sel_c_ni,
  input logic              proc_strobe_ni,
  input logic              ctrl_strobe_ni,
  input logic              advance_ni,
  input logic              write_all_ni,
  input logic              byte_wr_en_ni,
  input logic [LANES-1:0]  lane_wr_ni,
  input logic              out_en_ni,
  input logic              sleep_i,
  input logic              data_oe_o,
  input logic              active_q,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [LANES-1:0]  lane_we
);
  AST_GLOBAL_WRITE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!write_all_ni && active_q && !sleep_i) |-> (lane_we == '1)); // R1
  AST_LANE_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_all_ni && !byte_wr_en_ni) |-> ((lane_we & lane_wr_ni) == '0)); // R2
  AST_READ_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_all_ni && (byte_wr_en_ni || (&lane_wr_ni))) |-> (lane_we == '0)); // R3
  AST_DESEL_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_strobe_ni && !(!sel_a_ni && sel_b_i && !sel_c_ni)) |=> !data_oe_o); // R4
  AST_PROC_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strobe_ni && sel_a_ni && ctrl_strobe_ni && active_q && !sleep_i) |=> active_q); // R5
  AST_ADV_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !advance_ni && proc_strobe_ni && ctrl_strobe_ni && !sleep_i)
      |=> (cur_addr != $past(cur_addr))); // R7
  AST_SUSPEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_ni && proc_strobe_ni && ctrl_strobe_ni && !sleep_i) |=> $stable(cur_addr)); // R8
  AST_OE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_ni |-> !data_oe_o); // R9
  AST_WRITE_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|lane_we) && proc_strobe_ni && ctrl_strobe_ni) |=> !data_oe_o); // R10
  AST_SLEEP_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (!active_q && !data_oe_o)); // R11
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (.*);

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NL = 4;
  localparam int WORDS = 64;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr_i;
  logic sel_a_ni, sel_b_i, sel_c_ni, proc_strobe_ni, ctrl_strobe_ni, advance_ni;
  logic write_all_ni, byte_wr_en_ni, out_en_ni, sleep_i, burst_order_i;
  logic [NL-1:0] lane_wr_ni;
  logic [DW-1:0] data_i, data_o;
  logic data_oe_o;

  int checks = 0, fails = 0;
  logic [DW-1:0] mem_m [WORDS];
  logic [AW-1:0] base_m;
  logic          order_m;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sync_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL)) u_sync_burst_sram (.*);

  function automatic logic [AW-1:0] seq_addr(logic [AW-1:0] b, int k, logic il);
    logic [1:0] lo;
    lo = il ? (b[1:0] ^ 2'(k)) : (b[1:0] + 2'(k));
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                          logic gw, logic bwe, logic [NL-1:0] lanes);
    logic [DW-1:0] r;
    if (!gw) return new_w;
    r = old_w;
    if (!bwe)
      for (int i = 0; i < NL; i++)
        if (!lanes[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
    return r;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic quiet();
    sel_a_ni = 1'b0; sel_b_i = 1'b1; sel_c_ni = 1'b0;
    proc_strobe_ni = 1'b1; ctrl_strobe_ni = 1'b1; advance_ni = 1'b1;
    write_all_ni = 1'b1; byte_wr_en_ni = 1'b1; lane_wr_ni = '1;
    out_en_ni = 1'b0; sleep_i = 1'b0;
  endtask

  task automatic open_at(logic [AW-1:0] a, logic use_ctrl, logic il);
    addr_i = a; burst_order_i = il;
    if (use_ctrl) ctrl_strobe_ni = 1'b0; else proc_strobe_ni = 1'b0;
    step();
    proc_strobe_ni = 1'b1; ctrl_strobe_ni = 1'b1;
    base_m = a; order_m = il;
  endtask

  task automatic rd_burst(logic [AW-1:0] a, logic use_ctrl, logic il, string req);
    open_at(a, use_ctrl, il);
    check(req, {31'd0, data_oe_o}, 32'd1);
    check(req, data_o, mem_m[seq_addr(a, 0, il) % WORDS]);
    for (int k = 1; k < 4; k++) begin
      advance_ni = 1'b0;
      step();
      check(req, data_o, mem_m[seq_addr(a, k, il) % WORDS]);
    end
    advance_ni = 1'b1;
  endtask

  task automatic wr_burst(logic [AW-1:0] a, logic use_ctrl, logic il,
                          logic gw, logic bwe, logic [NL-1:0] lanes);
    int idx;
    open_at(a, use_ctrl, il);
    for (int k = 0; k < 4; k++) begin
      data_i = $urandom;
      write_all_ni = gw; byte_wr_en_ni = bwe; lane_wr_ni = lanes;
      advance_ni = 1'b0;
      step();
      idx = int'(seq_addr(a, k, il)) % WORDS;
      mem_m[idx] = merge(mem_m[idx], data_i, gw, bwe, lanes);
      if (gw && (bwe || &lanes)) check("R3", {31'd0, data_oe_o}, 32'd1);
      else check("R10", {31'd0, data_oe_o}, 32'd0);
    end
    quiet();
  endtask

  task automatic wr_one(logic [AW-1:0] a, logic [DW-1:0] d, logic gw, logic bwe,
                        logic [NL-1:0] lanes, string req);
    open_at(a, 1'b1, 1'b0);
    data_i = d; write_all_ni = gw; byte_wr_en_ni = bwe; lane_wr_ni = lanes;
    step();
    quiet();
    mem_m[a % WORDS] = merge(mem_m[a % WORDS], d, gw, bwe, lanes);
    open_at(a, 1'b1, 1'b0);
    check(req, data_o, mem_m[a % WORDS]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240601));
    quiet(); addr_i = '0; data_i = '0; burst_order_i = 1'b0;
    #(CLK_PERIOD * 2 + 1);
    check("R12", {31'd0, data_oe_o}, 32'd0);
    rst_ni = 1'b1;
    step();
    check("R12", {31'd0, data_oe_o}, 32'd0);

    // fill with global full-word writes (R1)
    for (int b = 0; b < WORDS; b += 4) wr_burst(AW'(b), 1'b1, 1'b0, 1'b0, 1'b1, '1);
    rd_burst(10'd0, 1'b0, 1'b0, "R1");
    rd_burst(10'd4, 1'b1, 1'b0, "R6");
    wr_one(10'd40, 32'hA1B2C3D4, 1'b0, 1'b0, 4'b0101, "R1");

    // per-lane writes and non-writes
    wr_one(10'd41, 32'h11223344, 1'b1, 1'b0, 4'b1010, "R2");
    wr_one(10'd42, 32'h55667788, 1'b1, 1'b0, 4'b0000, "R2");
    wr_one(10'd43, 32'hDEADBEEF, 1'b1, 1'b1, 4'b0000, "R3");
    wr_one(10'd44, 32'hCAFEF00D, 1'b1, 1'b0, 4'b1111, "R3");
    quiet();

    // burst orders from start offset 1
    rd_burst(10'd17, 1'b1, 1'b0, "R7");
    rd_burst(10'd17, 1'b1, 1'b1, "R7");
    advance_ni = 1'b0; step(); advance_ni = 1'b1;
    check("R7", data_o, mem_m[17]);

    // suspend
    open_at(10'd12, 1'b0, 1'b0);
    step();
    check("R8", data_o, mem_m[12]);
    advance_ni = 1'b0; step(); advance_ni = 1'b1;
    check("R8", data_o, mem_m[13]);

    // output enable without clock
    out_en_ni = 1'b1; #1;
    check("R9", {31'd0, data_oe_o}, 32'd0);
    check("R9", data_o, 32'd0);
    out_en_ni = 1'b0; #1;
    check("R9", data_o, mem_m[13]);

    // deselect
    open_at(10'd5, 1'b1, 1'b0);
    sel_b_i = 1'b0; proc_strobe_ni = 1'b0; step(); quiet();
    check("R4", {31'd0, data_oe_o}, 32'd0);
    advance_ni = 1'b0; step(); advance_ni = 1'b1;
    check("R4", {31'd0, data_oe_o}, 32'd0);
    sel_c_ni = 1'b1; ctrl_strobe_ni = 1'b0; step(); quiet();
    check("R4", {31'd0, data_oe_o}, 32'd0);

    // processor strobe ignored with sel_a high, controller strobe not
    open_at(10'd8, 1'b1, 1'b0);
    sel_a_ni = 1'b1; proc_strobe_ni = 1'b0; advance_ni = 1'b0; addr_i = 10'd30;
    step(); quiet();
    check("R5", data_o, mem_m[9]);
    sel_a_ni = 1'b1; ctrl_strobe_ni = 1'b0; step(); quiet();
    check("R5", {31'd0, data_oe_o}, 32'd0);

    // tri-state after write
    open_at(10'd20, 1'b1, 1'b0);
    data_i = 32'h0BADF00D; write_all_ni = 1'b0; step(); quiet();
    mem_m[20] = 32'h0BADF00D;
    check("R10", {31'd0, data_oe_o}, 32'd0);
    step();
    check("R10", {31'd0, data_oe_o}, 32'd0);
    advance_ni = 1'b0; step(); advance_ni = 1'b1;
    check("R10", data_o, mem_m[21]);

    // sleep
    open_at(10'd30, 1'b1, 1'b0);
    sleep_i = 1'b1; #1;
    check("R11", {31'd0, data_oe_o}, 32'd0);
    ctrl_strobe_ni = 1'b0; addr_i = 10'd31; data_i = '1; write_all_ni = 1'b0;
    step(); quiet();
    check("R11", {31'd0, data_oe_o}, 32'd0);
    step();
    check("R11", {31'd0, data_oe_o}, 32'd0);
    rd_burst(10'd28, 1'b1, 1'b0, "R11");

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % WORDS);
      if ($urandom % 2)
        rd_burst(a, 1'($urandom), 1'($urandom), "R7");
      else
        wr_burst(a, 1'($urandom), 1'($urandom), 1'($urandom % 3 != 0),
                 1'($urandom), NL'($urandom));
      quiet();
    end
    for (int b = 0; b < WORDS; b += 4) rd_burst(AW'(b), 1'b0, 1'b0, "R2");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule